// File: doc/BRIEF.md
# Serial ADC Interface Power-State Emulator

This block is the device-side digital model of a small serial-output converter, used on an FPGA to stand in for the real part or to test the controller that drives it. It watches an active-low chip select and a serial clock, both sampled asynchronously into the system clock domain. On each frame it shifts out a 16-bit word made of leading zeros followed by a sample taken from a parallel input, most significant bit first. The data line is enabled only while a frame is open and is otherwise released to high impedance, which is modelled by a separate output enable.

Next to the data path the block tracks a power state: normal, powered-down or waking. A frame that chip select closes early moves the state. A short glitch changes nothing, a mid-frame abort powers the device down, and a powered-down device needs one long dummy frame to wake. Frames that are not issued in the normal state shift out all ones and keep the data-valid flag low, so a controller model can tell invalid words from real ones.

Top module: `adc_emu_top`

## Requirements
- R1: The data output enable is low while chip select is high and high while a frame is open, a frame being opened by chip select falling and closed by it rising.
- R2: In a frame that opens in the normal state, the word is 4 zero bits followed by the 12-bit sample captured at chip select fall, MSB first; bit 15 is presented once chip select falls and bit 15-k once the k-th serial clock falling edge has been seen.
- R3: In the normal state, chip select rising after fewer than 2 serial clock falling edges leaves the state normal (state code 0).
- R4: In the normal state, chip select rising after 2 to 9 falling edges moves the state to powered-down (state code 1).
- R5: In the normal state, chip select rising after 10 or more falling edges leaves the state normal.
- R6: Chip select falling while powered-down moves the state to waking (state code 2), and that frame shifts out all ones for its first 16 bits.
- R7: While waking, chip select rising after fewer than 10 falling edges returns the state to powered-down.
- R8: While waking, the 16th falling edge of the frame moves the state to normal; the next frame carries valid data.
- R9: While waking, chip select rising after 10 to 15 falling edges moves the state to normal.
- R10: The data-valid flag is high only during a frame that opened in the normal state and is low at all other times.
- R11: After reset the state is normal and the output enable and data-valid flag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling and all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select from the controller, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the controller, asynchronous |
| sample_i | input | 12 | Sample value captured at the start of each frame |
| sdata_o | output | 1 | Serial data bit currently presented |
| sdata_oe_o | output | 1 | Output enable for the data line; low means high impedance |
| pwr_state_o | output | 2 | Power state: 0 normal, 1 powered-down, 2 waking |
| data_valid_o | output | 1 | High while the open frame carries a real sample |

## Verification
Every pin change passes two synchronizer flops and one edge register before the frame and power registers update, so a result is due on the third system clock edge after the pin moves. The bench changes one pin at a time and samples six clocks later, one nanosecond past the edge, so each check sees a settled value and never the edge itself. Both power-state sweeps close the frame after every count from 0 to 17 serial clock edges, which crosses both thresholds on either side.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
   typedef enum logic [1:0] {
      PWR_NORMAL = 2'd0,
      PWR_DOWN   = 2'd1,
      PWR_WAKING = 2'd2
   } pwr_state_t;
endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic rst_val_i,
   output logic level_o,
   output logic prev_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("adc_emu_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{rst_val_i}};
         prev_q  <= rst_val_i;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign prev_o  = prev_q;
endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame #(
   parameter int SAMPLE_W     = 12,
   parameter int LEAD_W       = 4,
   parameter bit INVALID_ONES = 1'b1,
   localparam int FRAME_W     = SAMPLE_W + LEAD_W,
   localparam int CNT_W       = $clog2(FRAME_W + 2)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_fall_i,
   input  logic                cs_rise_i,
   input  logic                sclk_fall_i,
   input  logic                word_ok_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic                in_frame_o,
   output logic [CNT_W-1:0]    cnt_o,
   output logic                sdata_o,
   output logic                valid_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               in_frame_q;
   logic               valid_q;
   logic [FRAME_W-1:0] bad_word;
   logic               fill_bit;

   generate
      if (INVALID_ONES) begin : g_fill_ones
         assign bad_word = '1;
         assign fill_bit = ~valid_q;
      end else begin : g_fill_zeros
         assign bad_word = '0;
         assign fill_bit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q    <= '0;
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
         valid_q    <= 1'b0;
      end else if (cs_fall_i) begin
         in_frame_q <= 1'b1;
         cnt_q      <= '0;
         valid_q    <= word_ok_i;
         shreg_q    <= word_ok_i ? {{LEAD_W{1'b0}}, sample_i} : bad_word;
      end else if (cs_rise_i) begin
         in_frame_q <= 1'b0;
         valid_q    <= 1'b0;
      end else if (sclk_fall_i && in_frame_q) begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         shreg_q <= {shreg_q[FRAME_W-2:0], fill_bit};
      end
   end

   assign in_frame_o = in_frame_q;
   assign cnt_o      = cnt_q;
   assign sdata_o    = shreg_q[FRAME_W-1];
   assign valid_o    = valid_q;
endmodule

// File: rtl/adc_emu_power.sv
module adc_emu_power
   import adc_emu_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int DOWN_EDGE = 2,
   parameter int WAKE_EDGE = 10,
   parameter int FULL_EDGE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_fall_i,
   input  logic             cs_rise_i,
   input  logic             sclk_fall_i,
   input  logic             in_frame_i,
   input  logic [CNT_W-1:0] cnt_i,
   output pwr_state_t       state_o
);
   localparam logic [CNT_W-1:0] DOWN_C = CNT_W'(DOWN_EDGE);
   localparam logic [CNT_W-1:0] WAKE_C = CNT_W'(WAKE_EDGE);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FULL_EDGE - 1);

   pwr_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         PWR_NORMAL: begin
            if (cs_rise_i && cnt_i >= DOWN_C && cnt_i < WAKE_C) state_d = PWR_DOWN;
         end
         PWR_DOWN: begin
            if (cs_fall_i) state_d = PWR_WAKING;
         end
         PWR_WAKING: begin
            if (cs_rise_i) begin
               state_d = (cnt_i < WAKE_C) ? PWR_DOWN : PWR_NORMAL;
            end else if (sclk_fall_i && in_frame_i && cnt_i == LAST_C) begin
               state_d = PWR_NORMAL;
            end
         end
         default: state_d = PWR_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PWR_NORMAL;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/adc_emu_top.sv
module adc_emu_top
   import adc_emu_pkg::*;
#(
   parameter int SAMPLE_W     = 12,
   parameter int LEAD_W       = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int DOWN_EDGE    = 2,
   parameter int WAKE_EDGE    = 10,
   parameter bit INVALID_ONES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n_i,
   input  logic                sclk_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic                sdata_o,
   output logic                sdata_oe_o,
   output logic [1:0]          pwr_state_o,
   output logic                data_valid_o
);
   localparam int FRAME_W = SAMPLE_W + LEAD_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);

   generate
      if (LEAD_W < 1 || SAMPLE_W < 1) begin : g_bad_width
         $error("adc_emu_top: word fields must be non-empty");
      end
      if (DOWN_EDGE < 1 || WAKE_EDGE <= DOWN_EDGE || WAKE_EDGE >= FRAME_W) begin : g_bad_edges
         $error("adc_emu_top: edge thresholds must satisfy 1 <= DOWN < WAKE < frame length");
      end
   endgenerate

   logic cs_lvl, cs_prev, sclk_lvl, sclk_prev;
   logic cs_fall, cs_rise, sclk_fall;
   logic in_frame;
   logic [CNT_W-1:0] frame_cnt;
   pwr_state_t state;

   adc_emu_sync #(.STAGES(SYNC_STAGES)) cs_sync_i (
      .clk(clk), .rst_n(rst_n), .pin_i(cs_n_i), .rst_val_i(1'b1),
      .level_o(cs_lvl), .prev_o(cs_prev)
   );

   adc_emu_sync #(.STAGES(SYNC_STAGES)) sclk_sync_i (
      .clk(clk), .rst_n(rst_n), .pin_i(sclk_i), .rst_val_i(1'b1),
      .level_o(sclk_lvl), .prev_o(sclk_prev)
   );

   assign cs_fall   = cs_prev & ~cs_lvl;
   assign cs_rise   = ~cs_prev & cs_lvl;
   assign sclk_fall = sclk_prev & ~sclk_lvl;

   adc_emu_frame #(
      .SAMPLE_W(SAMPLE_W), .LEAD_W(LEAD_W), .INVALID_ONES(INVALID_ONES)
   ) frame_i (
      .clk(clk), .rst_n(rst_n),
      .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_fall_i(sclk_fall),
      .word_ok_i(state == PWR_NORMAL), .sample_i(sample_i),
      .in_frame_o(in_frame), .cnt_o(frame_cnt),
      .sdata_o(sdata_o), .valid_o(data_valid_o)
   );

   adc_emu_power #(
      .CNT_W(CNT_W), .DOWN_EDGE(DOWN_EDGE), .WAKE_EDGE(WAKE_EDGE), .FULL_EDGE(FRAME_W)
   ) power_i (
      .clk(clk), .rst_n(rst_n),
      .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_fall_i(sclk_fall),
      .in_frame_i(in_frame), .cnt_i(frame_cnt), .state_o(state)
   );

   assign sdata_oe_o  = in_frame;
   assign pwr_state_o = state;
endmodule

// File: rtl/adc_emu_chk.sv
module adc_emu_chk
   import adc_emu_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int DOWN_EDGE = 2,
   parameter int WAKE_EDGE = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_fall,
   input logic             cs_rise,
   input logic [CNT_W-1:0] frame_cnt,
   input logic [1:0]       pwr_state_o,
   input logic             sdata_oe_o,
   input logic             data_valid_o
);
   localparam logic [CNT_W-1:0] DOWN_C = CNT_W'(DOWN_EDGE);
   localparam logic [CNT_W-1:0] WAKE_C = CNT_W'(WAKE_EDGE);

   a_r1_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !sdata_oe_o);

   a_r1_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> sdata_oe_o);

   a_r3_glitch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && pwr_state_o == PWR_NORMAL && frame_cnt < DOWN_C) |=> pwr_state_o == PWR_NORMAL);

   a_r4_abort_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && pwr_state_o == PWR_NORMAL && frame_cnt >= DOWN_C && frame_cnt < WAKE_C)
      |=> pwr_state_o == PWR_DOWN);

   a_r6_fall_starts_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && pwr_state_o == PWR_DOWN) |=> pwr_state_o == PWR_WAKING);

   a_r7_short_wake_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && pwr_state_o == PWR_WAKING && frame_cnt < WAKE_C) |=> pwr_state_o == PWR_DOWN);

   a_r9_long_wake_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && pwr_state_o == PWR_WAKING && frame_cnt >= WAKE_C) |=> pwr_state_o == PWR_NORMAL);

   a_r10_valid_only_normal: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> (pwr_state_o == PWR_NORMAL && sdata_oe_o));

   a_r11_state_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state_o != 2'd3);
endmodule

bind adc_emu_top adc_emu_chk #(
   .CNT_W(CNT_W), .DOWN_EDGE(DOWN_EDGE), .WAKE_EDGE(WAKE_EDGE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
   .frame_cnt(frame_cnt), .pwr_state_o(pwr_state_o),
   .sdata_oe_o(sdata_oe_o), .data_valid_o(data_valid_o)
);

// File: tb/adc_emu_top_tb_top.sv
`timescale 1ns/1ps
module adc_emu_top_tb_top;
   localparam int ST_NORMAL = 0;
   localparam int ST_DOWN   = 1;
   localparam int ST_WAKING = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic [11:0] sample = '0;
   logic        sdata, sdata_oe, data_valid;
   logic [1:0]  pwr_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   adc_emu_top dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sample_i(sample),
      .sdata_o(sdata), .sdata_oe_o(sdata_oe), .pwr_state_o(pwr_state), .data_valid_o(data_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge clk);
      #1;
   endtask

   // Opens a frame, gives n serial clock falling edges, closes it and checks everything.
   task automatic run_frame(input int n, input int start, input logic [11:0] smp);
      logic [15:0] word;
      bit ok;
      int end_exp;
      ok   = (start == ST_NORMAL);
      word = ok ? {4'b0000, smp} : 16'hFFFF;
      sample = smp;
      cs_n = 1'b0;
      settle();
      chk("R1 oe in frame", int'(sdata_oe), 1);
      chk("R10 valid at open", int'(data_valid), ok ? 1 : 0);
      chk(ok ? "R2 first bit" : "R6 first bit ones", int'(sdata), int'(word[15]));
      if (start == ST_DOWN) chk("R6 waking", int'(pwr_state), ST_WAKING);
      for (int k = 1; k <= n; k++) begin
         sclk = 1'b0;
         settle();
         if (k < 16) chk(ok ? "R2 data bit" : "R6 ones bit", int'(sdata), int'(word[15-k]));
         if (start == ST_DOWN && k == 15) chk("R8 still waking", int'(pwr_state), ST_WAKING);
         if (start == ST_DOWN && k == 16) chk("R8 awake at edge 16", int'(pwr_state), ST_NORMAL);
         if (start == ST_DOWN && k == 16) chk("R10 wake frame invalid", int'(data_valid), 0);
         sclk = 1'b1;
         settle();
      end
      cs_n = 1'b1;
      settle();
      chk("R1 oe released", int'(sdata_oe), 0);
      chk("R10 valid low idle", int'(data_valid), 0);
      if (start == ST_NORMAL) begin
         end_exp = (n >= 2 && n < 10) ? ST_DOWN : ST_NORMAL;
         if (n < 2)       chk("R3 glitch keeps normal", int'(pwr_state), end_exp);
         else if (n < 10) chk("R4 abort powers down", int'(pwr_state), end_exp);
         else             chk("R5 full frame stays normal", int'(pwr_state), end_exp);
      end else begin
         end_exp = (n < 10) ? ST_DOWN : ST_NORMAL;
         if (n < 10)      chk("R7 short wake rejected", int'(pwr_state), end_exp);
         else if (n < 16) chk("R9 wake after edge 10", int'(pwr_state), end_exp);
         else             chk("R8 wake complete", int'(pwr_state), end_exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         report();
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      chk("R11 reset oe", int'(sdata_oe), 0);
      chk("R11 reset valid", int'(data_valid), 0);
      chk("R11 reset state", int'(pwr_state), ST_NORMAL);
      rst_n = 1'b1;
      settle();
      chk("R11 state after release", int'(pwr_state), ST_NORMAL);

      // Sweep from normal over every edge count around both thresholds.
      for (int n = 0; n <= 17; n++) begin
         run_frame(n, ST_NORMAL, 12'((n * 293 + 91) & 12'hFFF));
         if (pwr_state == 2'(ST_DOWN)) run_frame(16, ST_DOWN, 12'h000);
      end

      // Sweep from powered-down over the same counts.
      for (int n = 0; n <= 17; n++) begin
         run_frame(5, ST_NORMAL, 12'((n * 611 + 7) & 12'hFFF));
         chk("R4 entered down", int'(pwr_state), ST_DOWN);
         run_frame(n, ST_DOWN, 12'hABC);
         if (pwr_state == 2'(ST_DOWN)) run_frame(16, ST_DOWN, 12'h123);
      end

      // Frame after a completed wake carries real data (R8).
      run_frame(4, ST_NORMAL, 12'h5A5);
      run_frame(16, ST_DOWN, 12'hFFF);
      run_frame(16, ST_NORMAL, 12'hC3E);
      run_frame(16, ST_NORMAL, 12'h801);

      done = 1'b1;
      report();
   end
endmodule